// File: doc/BRIEF.md
# Command Stream Method Expander

This block sits between a command-word source and the engines that consume register-style method writes. It reads a stream of 32-bit words, each group led by a header word, and turns every header and its data words into separate write transactions. Each write carries a subchannel number, a 12-bit method address in word units, and a 32-bit data value. A header states how many data words follow it, which subchannel they target, the first method address, and how that address moves from one data word to the next.

Four header forms are recognised. The incrementing form steps the method address after every data word. The fixed form sends every data word to the same method. The step-once form sends the first data word to the header's method and every later word to the method after it. The immediate form is a single word that forms a complete write: its data is a 13-bit field of the header, zero-extended. A header with a zero count produces nothing. An unknown opcode sets a sticky error flag and the word is discarded.

Both sides use valid/ready handshakes. Writes leave through a one-entry output register. While that register holds a write the consumer has not taken, no input word is accepted. A write is therefore never dropped or repeated.

Top module: `cmd_method_expander`

States: `ST_HEADER` (the next accepted word is read as a header) and `ST_PAYLOAD` (the next accepted word is a data word of the current header). Transitions: `ST_HEADER -> ST_PAYLOAD` on a burst header with a nonzero count. `ST_PAYLOAD -> ST_HEADER` when the last counted data word is accepted. Immediate, zero-count and unknown headers stay in `ST_HEADER`. Every other accepted data word stays in `ST_PAYLOAD`.

Header layout:
- bits [31:29]: opcode. 1 = incrementing, 3 = fixed, 4 = immediate, 5 = step-once. All other values are undefined.
- bits [28:16]: data-word count, or the immediate value.
- bits [15:13]: subchannel.
- bit [12]: ignored.
- bits [11:0]: method address.

## Requirements
- R1: After reset, `out_valid` is 0, `err_flag` is 0 and `in_ready` is 1.
- R2: With opcode 1 and count N, the next N accepted words become N writes to methods M, M+1, ... in order, where M is the header's method. The method address wraps modulo 4096.
- R3: With opcode 3 and count N, all N writes go to method M.
- R4: With opcode 5 and count N, the first write goes to M and the remaining N-1 writes go to M+1.
- R5: With opcode 4, the header alone produces one write to M. Its data is bits [28:16] of the header, zero-extended to 32 bits. The following word is read as a header.
- R6: A burst header (opcode 1, 3 or 5) with count 0 produces no write, and the following word is read as a header.
- R7: A header with opcode 0, 2, 6 or 7 produces no write and sets `err_flag`. The following word is read as a header.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the output write stays unchanged. Every write is delivered exactly once.
- R9: Every write carries the subchannel from bits [15:13] of the header that produced it.
- R10: Once set, `err_flag` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Header or data word |
| in_ready | output | 1 | Block accepts the input word this cycle |
| out_valid | output | 1 | Method write valid |
| out_ready | input | 1 | Consumer takes the write this cycle |
| out_subch | output | 3 | Subchannel of the write |
| out_method | output | 12 | Method address of the write |
| out_data | output | 32 | Data of the write |
| err_flag | output | 1 | Sticky undefined-opcode flag |

## Verification
`in_ready` depends combinationally on `out_valid` and `out_ready`, so a word is accepted at the first rising edge where both `in_valid` and `in_ready` are high. The write it produces appears on the outputs one cycle after that edge, and the error flag rises at the same edge as that write would. The bench drives inputs on the falling edge and samples the handshake one nanosecond later. Each delivered write is logged on the edge where it transfers and compared, in order, with a list the bench builds from the header rules. Stall behaviour is checked on every stalled cycle by comparing the held write with the value seen one cycle earlier.

// File: rtl/cme_pkg.sv
package cme_pkg;

    localparam int WORD_W = 32;
    localparam int OPC_W  = 3;
    localparam int CNT_W  = 13;
    localparam int SUBC_W = 3;
    localparam int MTHD_W = 12;

    localparam int OPC_LSB  = WORD_W - OPC_W;
    localparam int CNT_LSB  = OPC_LSB - CNT_W;
    localparam int SUBC_LSB = CNT_LSB - SUBC_W;
    localparam int MTHD_LSB = 0;

    localparam logic [OPC_W-1:0] OPC_STEP_EACH  = 3'd1;
    localparam logic [OPC_W-1:0] OPC_STEP_NEVER = 3'd3;
    localparam logic [OPC_W-1:0] OPC_IMMEDIATE  = 3'd4;
    localparam logic [OPC_W-1:0] OPC_STEP_FIRST = 3'd5;

    typedef enum logic [0:0] {
        ST_HEADER  = 1'b0,
        ST_PAYLOAD = 1'b1
    } fsm_e;

    typedef enum logic [1:0] {
        ADV_EACH  = 2'd0,
        ADV_NEVER = 2'd1,
        ADV_FIRST = 2'd2
    } adv_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [CNT_W-1:0]  cnt;
        logic [SUBC_W-1:0] subch;
        logic [MTHD_W-1:0] method;
    } hdr_t;

endpackage

// File: rtl/cme_hdr_decode.sv
module cme_hdr_decode
    import cme_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              fields,
    output logic              is_burst,
    output logic              is_imm,
    output logic              is_bad,
    output adv_e              adv
);

    always_comb begin
        fields.opc    = word[OPC_LSB +: OPC_W];
        fields.cnt    = word[CNT_LSB +: CNT_W];
        fields.subch  = word[SUBC_LSB +: SUBC_W];
        fields.method = word[MTHD_LSB +: MTHD_W];

        is_burst = 1'b0;
        is_imm   = 1'b0;
        is_bad   = 1'b0;
        adv      = ADV_EACH;
        unique case (fields.opc)
            OPC_STEP_EACH:  begin is_burst = 1'b1; adv = ADV_EACH;  end
            OPC_STEP_NEVER: begin is_burst = 1'b1; adv = ADV_NEVER; end
            OPC_STEP_FIRST: begin is_burst = 1'b1; adv = ADV_FIRST; end
            OPC_IMMEDIATE:  is_imm = 1'b1;
            default:        is_bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/cme_addr_step.sv
module cme_addr_step #(
    parameter int MW = 12
) (
    input  logic [MW-1:0]      cur,
    input  cme_pkg::adv_e      adv,
    input  logic               first,
    output logic [MW-1:0]      nxt
);

    import cme_pkg::*;

    logic [MW-1:0] plus_one;
    assign plus_one = cur + MW'(1);

    always_comb begin
        unique case (adv)
            ADV_EACH:  nxt = plus_one;
            ADV_NEVER: nxt = cur;
            ADV_FIRST: nxt = first ? plus_one : cur;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/cme_out_reg.sv
module cme_out_reg #(
    parameter int SW = 3,
    parameter int MW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] ld_subch,
    input  logic [MW-1:0] ld_method,
    input  logic [DW-1:0] ld_data,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [SW-1:0] out_subch,
    output logic [MW-1:0] out_method,
    output logic [DW-1:0] out_data
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_subch  <= '0;
            out_method <= '0;
            out_data   <= '0;
        end else if (load) begin
            out_valid  <= 1'b1;
            out_subch  <= ld_subch;
            out_method <= ld_method;
            out_data   <= ld_data;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
        end
    end

    // R8: a stalled write is held unchanged until taken
    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_subch) && $stable(out_method) && $stable(out_data)));

endmodule

// File: rtl/cmd_method_expander.sv
module cmd_method_expander
    import cme_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int SW = SUBC_W,
    parameter int MW = MTHD_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_word,
    output logic          in_ready,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [SW-1:0] out_subch,
    output logic [MW-1:0] out_method,
    output logic [DW-1:0] out_data,
    output logic          err_flag
);

    fsm_e state_q, state_d;

    hdr_t hdr;
    logic hdr_burst, hdr_imm, hdr_bad;
    adv_e hdr_adv;

    logic [SW-1:0] ctx_subch;
    logic [MW-1:0] ctx_method, ctx_method_nxt;
    logic [CW-1:0] ctx_left;
    adv_e          ctx_adv;
    logic          ctx_first;

    logic          accept;
    logic          emit, load_ctx, step_ctx, err_set;
    logic [SW-1:0] emit_subch;
    logic [MW-1:0] emit_method;
    logic [DW-1:0] emit_data;

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    cme_hdr_decode u_dec (
        .word     (in_word),
        .fields   (hdr),
        .is_burst (hdr_burst),
        .is_imm   (hdr_imm),
        .is_bad   (hdr_bad),
        .adv      (hdr_adv)
    );

    cme_addr_step #(.MW(MW)) u_step (
        .cur   (ctx_method),
        .adv   (ctx_adv),
        .first (ctx_first),
        .nxt   (ctx_method_nxt)
    );

    cme_out_reg #(.SW(SW), .MW(MW), .DW(DW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (emit),
        .ld_subch   (emit_subch),
        .ld_method  (emit_method),
        .ld_data    (emit_data),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_subch  (out_subch),
        .out_method (out_method),
        .out_data   (out_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HEADER;
        else        state_q <= state_d;
    end

    // Next state and per-cycle outputs
    always_comb begin
        state_d     = state_q;
        emit        = 1'b0;
        emit_subch  = '0;
        emit_method = '0;
        emit_data   = '0;
        load_ctx    = 1'b0;
        step_ctx    = 1'b0;
        err_set     = 1'b0;
        unique case (state_q)
            ST_HEADER: begin
                if (accept) begin
                    if (hdr_bad) begin
                        err_set = 1'b1;
                    end else if (hdr_imm) begin
                        emit        = 1'b1;
                        emit_subch  = hdr.subch;
                        emit_method = hdr.method;
                        emit_data   = DW'(hdr.cnt);
                    end else if (hdr_burst && hdr.cnt != '0) begin
                        load_ctx = 1'b1;
                        state_d  = ST_PAYLOAD;
                    end
                end
            end
            ST_PAYLOAD: begin
                if (accept) begin
                    emit        = 1'b1;
                    emit_subch  = ctx_subch;
                    emit_method = ctx_method;
                    emit_data   = in_word;
                    step_ctx    = 1'b1;
                    if (ctx_left == CW'(1)) state_d = ST_HEADER;
                end
            end
            default: state_d = ST_HEADER;
        endcase
    end

    // Header context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_subch  <= '0;
            ctx_method <= '0;
            ctx_left   <= '0;
            ctx_adv    <= ADV_EACH;
            ctx_first  <= 1'b0;
        end else if (load_ctx) begin
            ctx_subch  <= hdr.subch;
            ctx_method <= hdr.method;
            ctx_left   <= hdr.cnt;
            ctx_adv    <= hdr_adv;
            ctx_first  <= 1'b1;
        end else if (step_ctx) begin
            ctx_method <= ctx_method_nxt;
            ctx_left   <= ctx_left - CW'(1);
            ctx_first  <= 1'b0;
        end
    end

    // Sticky error
    always_ff @(posedge clk) begin
        if (!rst_n)       err_flag <= 1'b0;
        else if (err_set) err_flag <= 1'b1;
    end

    // R8: no input is taken while the output is stalled
    p_no_take_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R6: payload state always has words left to take
    p_left_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAYLOAD) |-> (ctx_left != '0));

    // R7: an undefined header raises the flag and yields no write
    p_bad_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HEADER && accept && hdr_bad) |=> (err_flag && !out_valid));

    // R10: error flag is sticky
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R5: an immediate header yields one write with its embedded value
    p_imm_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HEADER && accept && hdr_imm) |=>
            (out_valid && out_data == DW'($past(in_word[CNT_LSB +: CNT_W]))));

    // R2: incrementing bursts advance by one per word
    p_step_each_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAYLOAD && accept && ctx_adv == ADV_EACH && ctx_left > CW'(1)) |=>
            (ctx_method == MW'($past(ctx_method) + MW'(1))));

    // R3: fixed bursts never move
    p_step_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAYLOAD && accept && ctx_adv == ADV_NEVER) |=> $stable(ctx_method));

    // R4: step-once bursts move only after the first word
    p_step_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAYLOAD && accept && ctx_adv == ADV_FIRST && !ctx_first) |=>
            $stable(ctx_method));

endmodule

// File: tb/tb_cmd_method_expander.sv
module tb_cmd_method_expander;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [2:0]  out_subch;
    logic [11:0] out_method;
    logic [31:0] out_data;
    logic        err_flag;

    always #2 clk = ~clk;

    cmd_method_expander dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_subch  (out_subch),
        .out_method (out_method),
        .out_data   (out_data),
        .err_flag   (err_flag)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic stall_mode = 1'b0;
    int stall_err = 0;
    int hold_err = 0;
    logic prev_stalled = 1'b0;
    logic [46:0] prev_w = '0;
    logic [46:0] got_q[$];
    logic [46:0] exp_q[$];

    always @(negedge clk) begin
        cyc++;
        out_ready = !stall_mode || (cyc % 3 == 0);
    end

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (prev_stalled && (!out_valid || {out_subch, out_method, out_data} != prev_w))
                hold_err++;
            if (out_valid && !out_ready && in_ready) stall_err++;
            if (out_valid && out_ready) got_q.push_back({out_subch, out_method, out_data});
            prev_stalled = out_valid && !out_ready;
            prev_w = {out_subch, out_method, out_data};
        end else begin
            prev_stalled = 1'b0;
        end
    end

    function automatic logic [31:0] hdr(input int op, input int cnt, input int sc, input int m);
        return {3'(op), 13'(cnt), 3'(sc), 1'b0, 12'(m)};
    endfunction

    function automatic logic [46:0] ent(input int sc, input int m, input logic [31:0] d);
        return {3'(sc), 12'(m), d};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        stall_mode = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic compare(input string req);
        chk(got_q.size() == exp_q.size(), req, 64'(got_q.size()), 64'(exp_q.size()));
        foreach (exp_q[i]) begin
            if (i < got_q.size()) chk(got_q[i] == exp_q[i], req, 64'(got_q[i]), 64'(exp_q[i]));
        end
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 0);
        chk(err_flag == 1'b0, "R1 err_flag", 64'(err_flag), 0);
        chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 1);
    endtask

    task automatic t_incrementing();
        send(hdr(1, 3, 2, 'h010));
        send(32'hA000_0001);
        send(32'hA000_0002);
        send(32'hA000_0003);
        drain();
        exp_q.push_back(ent(2, 'h010, 32'hA000_0001));
        exp_q.push_back(ent(2, 'h011, 32'hA000_0002));
        exp_q.push_back(ent(2, 'h012, 32'hA000_0003));
        compare("R2 R9 incrementing");
        send(hdr(1, 2, 1, 'hFFF));
        send(32'h0000_0055);
        send(32'h0000_0066);
        drain();
        exp_q.push_back(ent(1, 'hFFF, 32'h0000_0055));
        exp_q.push_back(ent(1, 'h000, 32'h0000_0066));
        compare("R2 wrap");
    endtask

    task automatic t_fixed();
        send(hdr(3, 3, 5, 'h040));
        send(32'h1111_1111);
        send(32'h2222_2222);
        send(32'h3333_3333);
        drain();
        exp_q.push_back(ent(5, 'h040, 32'h1111_1111));
        exp_q.push_back(ent(5, 'h040, 32'h2222_2222));
        exp_q.push_back(ent(5, 'h040, 32'h3333_3333));
        compare("R3 fixed");
    endtask

    task automatic t_step_once();
        send(hdr(5, 4, 7, 'h100));
        send(32'hB000_0000);
        send(32'hB000_0001);
        send(32'hB000_0002);
        send(32'hB000_0003);
        drain();
        exp_q.push_back(ent(7, 'h100, 32'hB000_0000));
        exp_q.push_back(ent(7, 'h101, 32'hB000_0001));
        exp_q.push_back(ent(7, 'h101, 32'hB000_0002));
        exp_q.push_back(ent(7, 'h101, 32'hB000_0003));
        compare("R4 step-once");
    endtask

    task automatic t_immediate();
        send(hdr(4, 'h1ABC, 3, 'h022));
        send(hdr(1, 1, 6, 'h300));
        send(32'hC0DE_0001);
        drain();
        exp_q.push_back(ent(3, 'h022, 32'h0000_1ABC));
        exp_q.push_back(ent(6, 'h300, 32'hC0DE_0001));
        compare("R5 immediate");
    endtask

    task automatic t_zero_count();
        send(hdr(1, 0, 0, 'h005));
        send(hdr(3, 0, 2, 'h006));
        send(hdr(4, 7, 1, 'h009));
        drain();
        exp_q.push_back(ent(1, 'h009, 32'h0000_0007));
        compare("R6 zero count");
    endtask

    task automatic t_stall();
        stall_err = 0;
        hold_err = 0;
        @(negedge clk);
        stall_mode = 1'b1;
        send(hdr(1, 5, 4, 'h200));
        for (int i = 0; i < 5; i++) send(32'hD000_0000 + 32'(i));
        send(hdr(4, 'h0FF, 4, 'h2F0));
        drain();
        for (int i = 0; i < 5; i++) exp_q.push_back(ent(4, 'h200 + i, 32'hD000_0000 + 32'(i)));
        exp_q.push_back(ent(4, 'h2F0, 32'h0000_00FF));
        compare("R8 stall ordering");
        chk(stall_err == 0, "R8 in_ready low while stalled", 64'(stall_err), 0);
        chk(hold_err == 0, "R8 write held while stalled", 64'(hold_err), 0);
    endtask

    task automatic t_bad_opcode();
        #1;
        chk(err_flag == 1'b0, "R7 flag clear before", 64'(err_flag), 0);
        send(hdr(2, 1, 1, 'h010));
        send(hdr(4, 'h012, 1, 'h011));
        drain();
        exp_q.push_back(ent(1, 'h011, 32'h0000_0012));
        compare("R7 bad header dropped");
        chk(err_flag == 1'b1, "R7 flag set", 64'(err_flag), 1);
        send(hdr(0, 0, 0, 0));
        send(hdr(6, 2, 0, 0));
        send(hdr(7, 2, 0, 0));
        send(hdr(3, 1, 2, 'h050));
        send(32'hE000_0001);
        drain();
        exp_q.push_back(ent(2, 'h050, 32'hE000_0001));
        compare("R7 opcodes 0 6 7 dropped");
        chk(err_flag == 1'b1, "R10 flag sticky", 64'(err_flag), 1);
        do_reset();
        #1;
        chk(err_flag == 1'b0, "R10 flag cleared by reset", 64'(err_flag), 0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_incrementing();
        t_fixed();
        t_step_once();
        t_immediate();
        t_zero_count();
        t_stall();
        t_bad_opcode();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule